// File: doc/BRIEF.md
# Synthesizer Divider Chain and Phase Detector

This block is the digital core of an integer-N frequency synthesizer. Two dividers and a phase-frequency detector run on one fast system clock. One tick input strobes once per crystal cycle and another once per cycle of the prescaled oscillator. A fixed divider counts 512 crystal ticks to form the comparison reference. A programmable divider counts N oscillator ticks, with N a 15-bit ratio, to form the divided feedback signal. Both divided signals have close to 50% duty cycle, and each falls on its terminal count.

The detector compares the falling edges of the two divided signals. It commands the charge pump upward while the feedback edge leads, and downward while the reference edge leads. When neither command is active the pump is reported as high impedance, which is the locked condition. The register block supplies the following controls:
- a tristate override;
- a test routing bit, which puts both divided signals onto two port pins;
- the pump-current level;
- a bit that turns off the filter-output drive.

All times below are counted in system clock cycles. A tick is counted only on the clock edges where it is high.

Top module: `pll_synth_core`

## Requirements
- R1: `ref_div_o` falls on every 512th crystal tick. After each fall it stays low for 256 ticks, then stays high until the next fall. After reset the counter starts at zero with `ref_div_o` low.
- R2: `vco_div_o` falls on every Nth oscillator tick. After each fall it stays low for floor(N/2) ticks, then stays high for the rest of the period.
- R3: The divider takes a new ratio only at its terminal count, so a period already running keeps its length. The first period after reset uses N = 256. A `ratio_i` value below 256 is used as 256.
- R4: If the feedback signal falls while no reference fall is pending, `pump_up_o` rises one cycle after that fall. It falls one cycle after the next reference fall, so it is high for exactly the edge separation.
- R5: If the reference signal falls while no feedback fall is pending, `pump_dn_o` behaves the same way. It rises one cycle after the reference fall and lasts until one cycle after the next feedback fall.
- R6: When both divided signals fall in the same cycle, no pump command is produced. `pump_up_o` and `pump_dn_o` are never high together.
- R7: `pump_hiz_o` is 1 whenever no pump command is active. While `tristate_i` = 1, `pump_hiz_o` is 1 and both commands are held at 0.
- R8: `port_o[3:0]` drives ports P4..P7 (bit 0 = P4). With `test_route_i` = 0 it equals `port_reg_i`. With `test_route_i` = 1, bit 2 carries `ref_div_o`, bit 3 carries `vco_div_o`, and bits 1:0 still follow `port_reg_i`.
- R9: `pump_hi_o` follows `cur_hi_i`. `drive_en_o` is the inverse of `drive_off_i`.
- R10: During reset both divided outputs are 0, both commands are 0, and `pump_hiz_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_tick_i | input | 1 | One pulse per crystal cycle |
| vco_tick_i | input | 1 | One pulse per prescaled oscillator cycle |
| ratio_i | input | 15 | Feedback divide ratio N |
| tristate_i | input | 1 | Force pump to high impedance |
| test_route_i | input | 1 | Route divided signals to ports P6/P7 |
| cur_hi_i | input | 1 | Select high pump current |
| drive_off_i | input | 1 | Disable filter-output drive |
| port_reg_i | input | 4 | Register values for P4..P7 |
| ref_div_o | output | 1 | Divided reference |
| vco_div_o | output | 1 | Divided feedback |
| pump_up_o | output | 1 | Pump source command |
| pump_dn_o | output | 1 | Pump sink command |
| pump_hiz_o | output | 1 | Pump output high impedance |
| pump_hi_o | output | 1 | High pump-current level |
| drive_en_o | output | 1 | Filter-output drive enable |
| port_o | output | 4 | Port pins P4..P7 |

## Verification
The divider assertions assume a ratio of at least 2. The top module guarantees this by clamping `ratio_i` to 256 and tying the reference ratio to a constant. The detector assertions assume that a terminal-count pulse lasts exactly one cycle. This holds for any tick pattern, because a pulse needs a tick on the terminal count.

The random stimulus draws tick densities and ratios from 200 to 2000, so values below the clamp are exercised. It changes the control bits only every 256 cycles, so long stretches of both commands are seen. The directed phases use ticks on every cycle. They skip a fixed number of ticks on one input to set exact edge offsets, which makes lock, lead and lag cases with known pulse widths.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_state_t;
endpackage

// File: rtl/pll_divider.sv
module pll_divider #(
  parameter int CW        = 15,
  parameter int RST_RATIO = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] ratio_i,
  output logic          div_o,
  output logic          tc_o
);
  logic [CW-1:0] cnt_q, ratio_q, half;
  logic          div_q, tc_q, last, mid;

  assign half = ratio_q >> 1;
  assign last = (cnt_q == ratio_q - CW'(1));
  assign mid  = (cnt_q == half - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= CW'(RST_RATIO);
      div_q   <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= tick_i & last;
      if (tick_i) begin
        if (last) begin
          cnt_q   <= '0;
          div_q   <= 1'b0;
          ratio_q <= ratio_i;  // new ratio only at terminal count
        end else begin
          cnt_q <= cnt_q + CW'(1);
          if (mid) div_q <= 1'b1;
        end
      end
    end
  end

  assign div_o = div_q;
  assign tc_o  = tc_q;

  a_r1_r2_fall_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |-> (!div_q && $past(div_q)));
  a_r3_ratio_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> tc_q);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
  import pll_core_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_fall_i,
  input  logic       vco_fall_i,
  output pfd_state_t st_o
);
  pfd_state_t st_q;
  logic set_up, set_dn;

  assign set_up = st_q.up | vco_fall_i;
  assign set_dn = st_q.dn | ref_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (set_up && set_dn) begin
      st_q <= '0;  // both seen: clear, no overlap reaches the pump
    end else begin
      st_q.up <= set_up;
      st_q.dn <= set_dn;
    end
  end

  assign st_o = st_q;

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q.up && st_q.dn));
  a_r6_coincident: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fall_i && vco_fall_i && !st_q.up && !st_q.dn) |=> (!st_q.up && !st_q.dn));
  a_r4_up_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vco_fall_i && !ref_fall_i && !st_q.dn) |=> st_q.up);
  a_r5_dn_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fall_i && !vco_fall_i && !st_q.up) |=> st_q.dn);
endmodule

// File: rtl/pll_out_mux.sv
module pll_out_mux
  import pll_core_pkg::*;
#(
  parameter int PW      = 4,
  parameter int REF_BIT = 2,
  parameter int VCO_BIT = 3
) (
  input  pfd_state_t    st_i,
  input  logic          tristate_i,
  input  logic          test_route_i,
  input  logic          ref_div_i,
  input  logic          vco_div_i,
  input  logic [PW-1:0] port_reg_i,
  output logic          up_o,
  output logic          dn_o,
  output logic          hiz_o,
  output logic [PW-1:0] port_o
);
  assign up_o  = st_i.up & ~tristate_i;
  assign dn_o  = st_i.dn & ~tristate_i;
  assign hiz_o = tristate_i | ~(st_i.up | st_i.dn);

  for (genvar i = 0; i < PW; i++) begin : g_port
    if (i == REF_BIT) begin : g_ref
      assign port_o[i] = test_route_i ? ref_div_i : port_reg_i[i];
    end else if (i == VCO_BIT) begin : g_vco
      assign port_o[i] = test_route_i ? vco_div_i : port_reg_i[i];
    end else begin : g_reg
      assign port_o[i] = port_reg_i[i];
    end
  end
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_core_pkg::*;
#(
  parameter int N_W       = 15,
  parameter int MIN_N     = 256,
  parameter int REF_RATIO = 512,
  parameter int PW        = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xtal_tick_i,
  input  logic           vco_tick_i,
  input  logic [N_W-1:0] ratio_i,
  input  logic           tristate_i,
  input  logic           test_route_i,
  input  logic           cur_hi_i,
  input  logic           drive_off_i,
  input  logic [PW-1:0]  port_reg_i,
  output logic           ref_div_o,
  output logic           vco_div_o,
  output logic           pump_up_o,
  output logic           pump_dn_o,
  output logic           pump_hiz_o,
  output logic           pump_hi_o,
  output logic           drive_en_o,
  output logic [PW-1:0]  port_o
);
  localparam int REF_W = $clog2(REF_RATIO + 1);

  logic [N_W-1:0] n_eff;
  logic           ref_tc, vco_tc, ref_div, vco_div;
  pfd_state_t     st;

  assign n_eff = (ratio_i < N_W'(MIN_N)) ? N_W'(MIN_N) : ratio_i;

  pll_divider #(.CW(REF_W), .RST_RATIO(REF_RATIO)) i_ref_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(xtal_tick_i),
    .ratio_i(REF_W'(REF_RATIO)), .div_o(ref_div), .tc_o(ref_tc));

  pll_divider #(.CW(N_W), .RST_RATIO(MIN_N)) i_vco_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(vco_tick_i),
    .ratio_i(n_eff), .div_o(vco_div), .tc_o(vco_tc));

  pll_pfd i_pfd (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_fall_i(ref_tc),
    .vco_fall_i(vco_tc), .st_o(st));

  pll_out_mux #(.PW(PW)) i_mux (
    .st_i(st), .tristate_i(tristate_i), .test_route_i(test_route_i),
    .ref_div_i(ref_div), .vco_div_i(vco_div), .port_reg_i(port_reg_i),
    .up_o(pump_up_o), .dn_o(pump_dn_o), .hiz_o(pump_hiz_o), .port_o(port_o));

  assign ref_div_o  = ref_div;
  assign vco_div_o  = vco_div;
  assign pump_hi_o  = cur_hi_i;
  assign drive_en_o = ~drive_off_i;

  a_r10_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!ref_div_o && !vco_div_o && !pump_up_o && !pump_dn_o && pump_hiz_o));
endmodule

// File: tb/test_pll_synth_core.sv
module test_pll_synth_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xt = 1'b0, vt = 1'b0;
  logic [14:0] ratio = 15'd512;
  logic        t0 = 1'b0, t1 = 1'b0, cur = 1'b0, os = 1'b0;
  logic [3:0]  preg = 4'd0;
  logic        ref_div, vco_div, up, dn, hiz, phi, drv;
  logic [3:0]  port;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  int m_rc, m_vc, m_vr;
  bit m_rdiv, m_vdiv, m_rtc, m_vtc, m_up, m_dn;

  always #2.5 clk = ~clk;

  pll_synth_core i_pll_synth_core (
    .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xt), .vco_tick_i(vt),
    .ratio_i(ratio), .tristate_i(t0), .test_route_i(t1), .cur_hi_i(cur),
    .drive_off_i(os), .port_reg_i(preg), .ref_div_o(ref_div),
    .vco_div_o(vco_div), .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz),
    .pump_hi_o(phi), .drive_en_o(drv), .port_o(port));

  function automatic int clamp_n(input logic [14:0] n);
    return (n < 15'd256) ? 256 : int'(n);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rc = 0; m_vc = 0; m_vr = 256;
    m_rdiv = 0; m_vdiv = 0; m_rtc = 0; m_vtc = 0; m_up = 0; m_dn = 0;
  endtask

  // called at a negedge: apply ticks, advance one clock, compare at next negedge
  task automatic step(input bit x, input bit v);
    bit su, sd, nu, nd, nrtc, nvtc;
    logic [3:0] exp_port;
    xt = x; vt = v;
    su = m_up | m_vtc; sd = m_dn | m_rtc;
    nu = (su && sd) ? 1'b0 : su;
    nd = (su && sd) ? 1'b0 : sd;
    nrtc = x && (m_rc == 511);
    if (x) begin
      if (m_rc == 511) begin m_rc = 0; m_rdiv = 0; end
      else begin if (m_rc == 255) m_rdiv = 1; m_rc++; end
    end
    nvtc = v && (m_vc == m_vr - 1);
    if (v) begin
      if (m_vc == m_vr - 1) begin m_vc = 0; m_vdiv = 0; m_vr = clamp_n(ratio); end
      else begin if (m_vc == m_vr / 2 - 1) m_vdiv = 1; m_vc++; end
    end
    m_rtc = nrtc; m_vtc = nvtc; m_up = nu; m_dn = nd;
    @(posedge clk);
    @(negedge clk);
    exp_port = t1 ? {m_vdiv, m_rdiv, preg[1:0]} : preg;
    chk(ref_div === m_rdiv, "R1 ref_div", int'(ref_div), int'(m_rdiv));
    chk(vco_div === m_vdiv, "R2 R3 vco_div", int'(vco_div), int'(m_vdiv));
    chk(up === (m_up && !t0), "R4 pump_up", int'(up), int'(m_up && !t0));
    chk(dn === (m_dn && !t0), "R5 pump_dn", int'(dn), int'(m_dn && !t0));
    chk(!(up && dn), "R6 overlap", int'(up && dn), 0);
    chk(hiz === (t0 || !(m_up || m_dn)), "R7 pump_hiz", int'(hiz), int'(t0 || !(m_up || m_dn)));
    chk(port === exp_port, "R8 port", int'(port), int'(exp_port));
    chk(phi === cur && drv === !os, "R9 level/drive", int'({phi, drv}), int'({cur, !os}));
  endtask

  task automatic run_both(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1);
  endtask

  // max consecutive up/dn run and total cycles of each over n steps
  task automatic measure(input int n, output int up_max, output int dn_max,
                         output int up_cnt, output int dn_cnt, output int hiz_cnt);
    int ur, dr;
    ur = 0; dr = 0; up_max = 0; dn_max = 0; up_cnt = 0; dn_cnt = 0; hiz_cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1);
      ur = up ? ur + 1 : 0;
      dr = dn ? dr + 1 : 0;
      if (ur > up_max) up_max = ur;
      if (dr > dn_max) dn_max = dr;
      if (up) up_cnt++;
      if (dn) dn_cnt++;
      if (hiz) hiz_cnt++;
    end
  endtask

  task automatic wait_vfall(output int n);
    logic prev;
    n = 0;
    prev = vco_div;
    forever begin
      step(1'b1, 1'b1);
      n++;
      if (prev && !vco_div) break;
      prev = vco_div;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int um, dm, uc, dc, hc, p1, p2, p3;
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk); @(negedge clk);
    // R10: reset state
    chk(!ref_div && !vco_div, "R10 divided outputs", int'({ref_div, vco_div}), 0);
    chk(!up && !dn && hiz, "R10 pump idle", int'({up, dn, hiz}), 1);
    rst_n = 1'b1;

    // align both dividers: 1000 ticks, then hold feedback for 256 ticks
    run_both(1000);
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0);
    measure(2100, um, dm, uc, dc, hc);
    chk(uc == 0 && dc == 0, "R6 locked no command", uc + dc, 0);
    chk(hc == 2100, "R7 locked high impedance", hc, 2100);

    // reference delayed by 10 ticks: feedback leads
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    run_both(600);
    measure(1100, um, dm, uc, dc, hc);
    chk(um == 10, "R4 up pulse width", um, 10);
    chk(dc == 0, "R4 no down while leading", dc, 0);

    // tristate override during lead
    t0 = 1'b1;
    measure(1100, um, dm, uc, dc, hc);
    chk(uc == 0 && dc == 0, "R7 tristate masks commands", uc + dc, 0);
    chk(hc == 1100, "R7 tristate high impedance", hc, 1100);
    t0 = 1'b0;

    // feedback held 20 ticks: now lags by 10
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    run_both(600);
    measure(1100, um, dm, uc, dc, hc);
    chk(dm == 10, "R5 down pulse width", dm, 10);
    chk(uc == 0, "R5 no up while lagging", uc, 0);

    // test routing with distinct register pattern
    t1 = 1'b1; preg = 4'b0101; cur = 1'b1; os = 1'b1;
    run_both(1200);
    t1 = 1'b0; cur = 1'b0; os = 1'b0;
    run_both(50);

    // ratio update at terminal count, and clamp
    wait_vfall(p1);
    ratio = 15'd300;
    wait_vfall(p1);
    ratio = 15'd100;
    wait_vfall(p2);
    wait_vfall(p3);
    chk(p1 == 512, "R3 running period kept", p1, 512);
    chk(p2 == 300, "R3 new ratio after terminal", p2, 300);
    chk(p3 == 256, "R3 ratio clamped", p3, 256);

    // random phase
    for (int i = 0; i < 16000; i++) begin
      if (i % 256 == 0) begin
        ratio = 15'(200 + $urandom % 1800);
        t0 = ($urandom % 4) == 0;
        t1 = $urandom % 2;
        cur = $urandom % 2;
        os = $urandom % 2;
        preg = 4'($urandom);
      end
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule